// File: doc/BRIEF.md
# USB IN Endpoint Bank Controller

This block coordinates software and a USB device packet engine for one IN endpoint built from one or two data banks. Each bank is either held by software, which fills it with the next payload, or held by hardware, which is waiting for the host to collect it. When the bank software works on is free, the block raises a transmit-ready flag together with a software-ownership flag. It drives an endpoint interrupt while transmit-ready and its enable are both set. Software hands a filled bank over by writing one to the release bit of the clear register. In two-bank mode, the same write steps to the other bank.

On the packet side, every IN token gets an immediate answer. The block returns DATA from the oldest bank held by hardware, or NAK when hardware holds no bank. A host ACK returns that bank to software. Two pointers track the banks: one marks the bank software fills next, the other the bank hardware sends next. With two banks, both pointers walk the banks in the same order, so payloads leave in the order they were released.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: When the bank software points to becomes free while software holds no bank, the transmit-ready flag and the ownership flag both become 1 on the same clock edge.
- R2: `irq` is 1 exactly while the transmit-ready flag and the interrupt enable are both 1. The enable is set by SET bit 0 and cleared by CLR bit 0.
- R3: Writing CLR bit 1 clears only the transmit-ready flag. The ownership flag, busy bits and pointers keep their values.
- R4: Writing CLR bit 2 while the ownership flag is 1 marks the software bank busy. When `cfg_multi`=1, the same write moves the software pointer to the next bank.
- R5: After a release, the ownership and transmit-ready flags are set again on the same edge only if the new software bank is free. Otherwise the ownership flag reads 0.
- R6: An IN token (`tok_in`=1) while no bank is busy gives `tok_nak`=1 and `tok_data`=0 in the same cycle.
- R7: An IN token while the hardware bank is busy gives `tok_data`=1, with `tok_bank` naming that bank. `host_ack`=1 frees that bank and, when `cfg_multi`=1, moves the hardware pointer.
- R8: With two banks, released banks are sent alternately: bank 0, then bank 1, then bank 0.
- R9: With `cfg_multi`=0, both pointers stay at bank 0.
- R10: Zero bits written to SET or CLR have no effect. A release written while the ownership flag is 0 is ignored.
- R11: If the transmit-ready flag is set by hardware and cleared by software on the same edge, it ends at 1.
- R12: Reset frees all banks, puts both pointers at 0 and clears every flag. No flag rises while `ep_enable`=0. The first edge with `ep_enable`=1 raises both flags.
- R13: Register addresses are 0 CTRL (read: bit 0 interrupt enable), 1 SET (write), 2 CLR (write) and 3 STATUS (read). STATUS holds bit 0 transmit-ready, bit 1 ownership, bit 2 interrupt enable, bit 4 software pointer, bit 5 hardware pointer, and bits 7:6 busy bits of banks 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_enable | input | 1 | Endpoint enabled |
| cfg_multi | input | 1 | 1 selects two banks, 0 selects one |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| tok_in | input | 1 | IN token from the host this cycle |
| host_ack | input | 1 | Host acknowledged the DATA packet |
| tok_data | output | 1 | Answer the token with DATA |
| tok_nak | output | 1 | Answer the token with NAK |
| tok_bank | output | PTR_W | Bank to send |
| irq | output | 1 | Endpoint interrupt |

## Verification
The bench goes after three cases. The first is a release that finds the other bank already free: a design that dropped the recompute would leave the ownership flag low and stall software. The second is a release written while software owns nothing, which a careless decode would turn into a second busy bank and a spurious DATA. The third is an ACK arriving on the same edge as a transmit-ready clear: a design where the clear wins loses the event and the interrupt. The bench also follows the send order across the pointer wrap. A design with misaligned pointers would send the wrong bank, or NAK while data waits.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_SET  = 2'd1;
    localparam logic [1:0] ADDR_CLR  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int BIT_IEN   = 0;
    localparam int BIT_TXRDY = 1;
    localparam int BIT_REL   = 2;

    typedef struct packed {
        logic ien_set;
        logic ien_clr;
        logic txrdy_clr;
        logic own_clr;
    } reg_cmd_t;

endpackage

// File: rtl/usb_in_ep_regif.sv
module usb_in_ep_regif
    import usb_in_ep_pkg::*;
#(
    parameter int DW        = 8,
    parameter int MAX_BANKS = 2,
    parameter int PTR_W     = 1
) (
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    input  logic                 txrdy_q,
    input  logic                 own_q,
    input  logic                 ien_q,
    input  logic [PTR_W-1:0]     sw_ptr_q,
    input  logic [PTR_W-1:0]     hw_ptr_q,
    input  logic [MAX_BANKS-1:0] busy_q,
    output reg_cmd_t             cmd,
    output logic [DW-1:0]        reg_rdata
);

    localparam int STAT_W = 4 + 2 * PTR_W + MAX_BANKS;

    logic              wr_set;
    logic              wr_clr;
    logic [STAT_W-1:0] stat_vec;
    logic              unused_wbits;

    assign wr_set = reg_wr && (reg_addr == ADDR_SET);
    assign wr_clr = reg_wr && (reg_addr == ADDR_CLR);

    always_comb begin
        cmd.ien_set   = wr_set && reg_wdata[BIT_IEN];
        cmd.ien_clr   = wr_clr && reg_wdata[BIT_IEN];
        cmd.txrdy_clr = wr_clr && reg_wdata[BIT_TXRDY];
        cmd.own_clr   = wr_clr && reg_wdata[BIT_REL];
    end

    assign unused_wbits = ^reg_wdata[DW-1:BIT_REL+1];

    assign stat_vec = {busy_q, hw_ptr_q, sw_ptr_q, 1'b0, ien_q, own_q, txrdy_q};

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = DW'(ien_q);
            ADDR_STAT: reg_rdata = DW'(stat_vec);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/usb_in_ep_banks.sv
module usb_in_ep_banks #(
    parameter int MAX_BANKS = 2,
    parameter int PTR_W     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_multi,
    input  logic                 release_bank,
    input  logic                 tok_in,
    input  logic                 host_ack,
    output logic                 cur_free_d,
    output logic                 tok_data,
    output logic                 tok_nak,
    output logic [PTR_W-1:0]     tok_bank,
    output logic [MAX_BANKS-1:0] busy_q,
    output logic [PTR_W-1:0]     sw_ptr_q,
    output logic [PTR_W-1:0]     hw_ptr_q
);

    localparam logic [PTR_W-1:0] LAST_BANK = PTR_W'(MAX_BANKS - 1);

    typedef struct packed {
        logic [MAX_BANKS-1:0] busy;
        logic [PTR_W-1:0]     sw_ptr;
        logic [PTR_W-1:0]     hw_ptr;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     sent_ok;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                  input logic multi);
        if (!multi || p == LAST_BANK) return '0;
        return p + PTR_W'(1);
    endfunction

    assign sent_ok = host_ack && st_q.busy[st_q.hw_ptr];

    always_comb begin
        st_d = st_q;
        if (release_bank) begin
            st_d.busy[st_q.sw_ptr] = 1'b1;
            st_d.sw_ptr            = step_ptr(st_q.sw_ptr, cfg_multi);
        end
        if (sent_ok) begin
            st_d.busy[st_q.hw_ptr] = 1'b0;
            st_d.hw_ptr            = step_ptr(st_q.hw_ptr, cfg_multi);
        end
        cur_free_d = !st_d.busy[st_d.sw_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tok_data = tok_in &&  st_q.busy[st_q.hw_ptr];
    assign tok_nak  = tok_in && !st_q.busy[st_q.hw_ptr];
    assign tok_bank = st_q.hw_ptr;
    assign busy_q   = st_q.busy;
    assign sw_ptr_q = st_q.sw_ptr;
    assign hw_ptr_q = st_q.hw_ptr;

    AST_RELEASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        release_bank |=> st_q.busy[$past(st_q.sw_ptr)]) else $error("release did not mark bank busy"); // R4
    AST_NAK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in && st_q.busy == '0) |-> (tok_nak && !tok_data)) else $error("token without busy bank not NAKed"); // R6
    AST_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        sent_ok |=> !st_q.busy[$past(st_q.hw_ptr)]) else $error("ACK did not free bank"); // R7
    AST_SINGLE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_multi |=> (st_q.sw_ptr == $past(st_q.sw_ptr) && st_q.hw_ptr == $past(st_q.hw_ptr))) else $error("pointer moved in single-bank mode"); // R9

endmodule

// File: rtl/usb_in_ep_flags.sv
module usb_in_ep_flags
    import usb_in_ep_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ep_enable,
    input  reg_cmd_t cmd,
    input  logic     cur_free_d,
    output logic     release_bank,
    output logic     own_q,
    output logic     txrdy_q,
    output logic     ien_q,
    output logic     irq
);

    typedef struct packed {
        logic own;
        logic txrdy;
        logic ien;
    } flag_st_t;

    flag_st_t fl_d, fl_q;
    logic     own_kept;
    logic     rise;

    assign release_bank = cmd.own_clr && fl_q.own;

    always_comb begin
        own_kept    = fl_q.own && !cmd.own_clr;
        rise        = ep_enable && !own_kept && cur_free_d;
        fl_d.own    = own_kept || rise;
        fl_d.txrdy  = rise || (fl_q.txrdy && !cmd.txrdy_clr);
        fl_d.ien    = cmd.ien_set || (fl_q.ien && !cmd.ien_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign own_q   = fl_q.own;
    assign txrdy_q = fl_q.txrdy;
    assign ien_q   = fl_q.ien;
    assign irq     = fl_q.txrdy && fl_q.ien;

    AST_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.own) |-> fl_q.txrdy) else $error("ownership rose without transmit-ready"); // R1
    AST_TXCLR_KEEPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.txrdy_clr && fl_q.own && !cmd.own_clr) |=> fl_q.own) else $error("transmit-ready clear touched ownership"); // R3
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && cmd.txrdy_clr) |=> fl_q.txrdy) else $error("software clear beat hardware set"); // R11
    AST_NO_RISE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ep_enable && !fl_q.own) |=> !fl_q.own) else $error("flag rose while disabled"); // R12

endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
    import usb_in_ep_pkg::*;
#(
    parameter int DW        = 8,
    parameter int MAX_BANKS = 2,
    parameter int PTR_W     = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ep_enable,
    input  logic             cfg_multi,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             tok_in,
    input  logic             host_ack,
    output logic             tok_data,
    output logic             tok_nak,
    output logic [PTR_W-1:0] tok_bank,
    output logic             irq
);

    reg_cmd_t             cmd;
    logic                 cur_free_d;
    logic                 release_bank;
    logic                 own_q;
    logic                 txrdy_q;
    logic                 ien_q;
    logic [MAX_BANKS-1:0] busy_q;
    logic [PTR_W-1:0]     sw_ptr_q;
    logic [PTR_W-1:0]     hw_ptr_q;

    usb_in_ep_regif #(.DW(DW), .MAX_BANKS(MAX_BANKS), .PTR_W(PTR_W)) regif_i (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .txrdy_q   (txrdy_q),
        .own_q     (own_q),
        .ien_q     (ien_q),
        .sw_ptr_q  (sw_ptr_q),
        .hw_ptr_q  (hw_ptr_q),
        .busy_q    (busy_q),
        .cmd       (cmd),
        .reg_rdata (reg_rdata)
    );

    usb_in_ep_flags flags_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ep_enable    (ep_enable),
        .cmd          (cmd),
        .cur_free_d   (cur_free_d),
        .release_bank (release_bank),
        .own_q        (own_q),
        .txrdy_q      (txrdy_q),
        .ien_q        (ien_q),
        .irq          (irq)
    );

    usb_in_ep_banks #(.MAX_BANKS(MAX_BANKS), .PTR_W(PTR_W)) banks_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_multi    (cfg_multi),
        .release_bank (release_bank),
        .tok_in       (tok_in),
        .host_ack     (host_ack),
        .cur_free_d   (cur_free_d),
        .tok_data     (tok_data),
        .tok_nak      (tok_nak),
        .tok_bank     (tok_bank),
        .busy_q       (busy_q),
        .sw_ptr_q     (sw_ptr_q),
        .hw_ptr_q     (hw_ptr_q)
    );

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (reg_addr != ADDR_CTRL || reg_rdata[0])) else $error("interrupt without enable"); // R2

endmodule

// File: tb/usb_in_ep_ctrl_tb_top.sv
module usb_in_ep_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] OP_IDLE = 3'd0;
    localparam logic [2:0] OP_SET  = 3'd1;
    localparam logic [2:0] OP_CLR  = 3'd2;
    localparam logic [2:0] OP_TOK  = 3'd3;
    localparam logic [2:0] OP_ACK  = 3'd4;

    localparam logic [1:0] RS_NONE = 2'd0;
    localparam logic [1:0] RS_NAK  = 2'd1;
    localparam logic [1:0] RS_DATA = 2'd2;

    localparam int NV = 20;
    // {multi, op, wdata, expected status, expected response, expected bank}
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, OP_IDLE, 8'h00, 8'h03, RS_NONE, 1'b0},
        {1'b0, OP_SET,  8'h01, 8'h07, RS_NONE, 1'b0},
        {1'b0, OP_CLR,  8'h02, 8'h06, RS_NONE, 1'b0},
        {1'b0, OP_TOK,  8'h00, 8'h06, RS_NAK,  1'b0},
        {1'b0, OP_CLR,  8'h04, 8'h44, RS_NONE, 1'b0},
        {1'b0, OP_CLR,  8'h04, 8'h44, RS_NONE, 1'b0},
        {1'b0, OP_TOK,  8'h00, 8'h44, RS_DATA, 1'b0},
        {1'b0, OP_ACK,  8'h00, 8'h07, RS_NONE, 1'b0},
        {1'b0, OP_CLR,  8'h00, 8'h07, RS_NONE, 1'b0},
        {1'b1, OP_CLR,  8'h02, 8'h06, RS_NONE, 1'b0},
        {1'b1, OP_CLR,  8'h04, 8'h57, RS_NONE, 1'b0},
        {1'b1, OP_CLR,  8'h02, 8'h56, RS_NONE, 1'b0},
        {1'b1, OP_CLR,  8'h04, 8'hC4, RS_NONE, 1'b0},
        {1'b1, OP_TOK,  8'h00, 8'hC4, RS_DATA, 1'b0},
        {1'b1, OP_ACK,  8'h00, 8'hA7, RS_NONE, 1'b0},
        {1'b1, OP_TOK,  8'h00, 8'hA7, RS_DATA, 1'b1},
        {1'b1, OP_CLR,  8'h02, 8'hA6, RS_NONE, 1'b0},
        {1'b1, OP_ACK,  8'h00, 8'h06, RS_NONE, 1'b0},
        {1'b1, OP_CLR,  8'h04, 8'h57, RS_NONE, 1'b0},
        {1'b1, OP_TOK,  8'h00, 8'h57, RS_DATA, 1'b0}
    };
    localparam string VTAG [NV] = '{
        "R12", "R13", "R3", "R6", "R9", "R10", "R7", "R1", "R10", "R3",
        "R5", "R3", "R4", "R8", "R7", "R8", "R3", "R7", "R5", "R8"
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ep_enable = 1'b0;
    logic       cfg_multi = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd3;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tok_in = 1'b0;
    logic       host_ack = 1'b0;
    logic       tok_data;
    logic       tok_nak;
    logic [0:0] tok_bank;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    usb_in_ep_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ep_enable (ep_enable),
        .cfg_multi (cfg_multi),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tok_in    (tok_in),
        .host_ack  (host_ack),
        .tok_data  (tok_data),
        .tok_nak   (tok_nak),
        .tok_bank  (tok_bank),
        .irq       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, check token answer before the edge,
    // then check status and irq after the rising edge
    task automatic step(input logic wr, input logic [1:0] addr, input logic [7:0] wd,
                        input logic tok, input logic ack, input logic [1:0] rs,
                        input logic bank, input logic [7:0] st, input string tag);
        @(negedge clk);
        reg_wr = wr; reg_addr = addr; reg_wdata = wd; tok_in = tok; host_ack = ack;
        #1;
        if (tok) begin
            chk(tag, {30'd0, tok_data, tok_nak}, (rs == RS_DATA) ? 2 : 1);
            if (rs == RS_DATA) chk(tag, int'(tok_bank), int'(bank));
        end
        @(posedge clk);
        #2;
        reg_wr = 1'b0; tok_in = 1'b0; host_ack = 1'b0; reg_addr = 2'd3; reg_wdata = 8'h00;
        #1;
        chk(tag, int'(reg_rdata), int'(st));
        chk({tag, "/R2"}, int'(irq), int'(st[0] & st[2]));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R12: reset state, nothing rises while disabled
        repeat (3) @(posedge clk);
        #1;
        chk("R12", int'(reg_rdata), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b0, 2'd3, 8'h00, 1'b0, 1'b0, RS_NONE, 1'b0, 8'h00, "R12");
        // first enabled edge raises both flags
        ep_enable = 1'b1;
        @(negedge clk);
        @(posedge clk);
        #3;
        chk("R12", int'(reg_rdata), 3);

        for (int v = 0; v < NV; v++) begin
            logic [22:0] e;
            e = VEC[v];
            cfg_multi = e[22];
            case (e[21:19])
                OP_SET:  step(1'b1, 2'd1, e[18:11], 1'b0, 1'b0, e[2:1], e[0], e[10:3], VTAG[v]);
                OP_CLR:  step(1'b1, 2'd2, e[18:11], 1'b0, 1'b0, e[2:1], e[0], e[10:3], VTAG[v]);
                OP_TOK:  step(1'b0, 2'd3, 8'h00,    1'b1, 1'b0, e[2:1], e[0], e[10:3], VTAG[v]);
                OP_ACK:  step(1'b0, 2'd3, 8'h00,    1'b0, 1'b1, e[2:1], e[0], e[10:3], VTAG[v]);
                default: step(1'b0, 2'd3, 8'h00,    1'b0, 1'b0, e[2:1], e[0], e[10:3], VTAG[v]);
            endcase
        end

        // R11: hardware raise and software clear on the same edge
        step(1'b1, 2'd2, 8'h02, 1'b0, 1'b0, RS_NONE, 1'b0, 8'h56, "R3");
        step(1'b1, 2'd2, 8'h04, 1'b0, 1'b0, RS_NONE, 1'b0, 8'hC4, "R4");
        step(1'b1, 2'd2, 8'h02, 1'b0, 1'b1, RS_NONE, 1'b0, 8'hA7, "R11");
        // R10: zero write to SET changes nothing
        step(1'b1, 2'd1, 8'h00, 1'b0, 1'b0, RS_NONE, 1'b0, 8'hA7, "R10");
        // R2: enable cleared, interrupt drops while transmit-ready stays
        step(1'b1, 2'd2, 8'h01, 1'b0, 1'b0, RS_NONE, 1'b0, 8'hA3, "R2");
        // R13: CTRL readback of the enable
        @(negedge clk);
        reg_addr = 2'd0;
        #1;
        chk("R13", int'(reg_rdata), 0);
        reg_addr = 2'd3;
        // R12: reset mid-run returns to the free state, then flags rise again
        rst_n = 1'b0;
        #1;
        chk("R12", int'(reg_rdata), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #3;
        chk("R12", int'(reg_rdata), 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule